// File: doc/BRIEF.md
# Branch Target and Next Program Counter Unit

This combinational unit decides where an 8-bit controller with a 16-bit code space fetches its next instruction. The decode stage gives it the address of the sequential next instruction, a 4-bit branch class and every operand a branch can use. In the same cycle the unit returns the next program counter, a flag that tells whether the flow changed, the carry that a compare-and-branch leaves, the decremented loop count, and the return address that a call pushes.

The unit forms targets in five ways. A relative target adds a sign-extended 8-bit offset to the sequential address. A page target keeps the upper five bits of the sequential address and places an 11-bit field below them. An absolute target is a full 16-bit address. An indexed target is the data pointer plus the accumulator. The sequential address is the fifth choice. The conditional classes test the accumulator for zero, the carry, a selected bit, operand inequality, or a decremented count that is not zero. All of these use the relative target.

Top module: `nextpc_unit`

## Requirements
- R1: Class 0 (sequential) gives next_pc = seq_pc and taken = 0. Every conditional class whose condition is false also gives next_pc = seq_pc and taken = 0.
- R2: Class 1 (short jump) is always taken. Its target is seq_pc plus rel_off sign-extended to 16 bits, modulo 2^16 (seq_pc 0015h with offset FEh gives 0013h).
- R3: Class 2 (page jump) and class 13 (page call) are always taken. Their target is {seq_pc[15:11], page_addr[10:0]}, so the upper bits come from the address after the instruction.
- R4: Class 3 (long jump) and class 14 (long call) are always taken with target abs_addr. rel_off, page_addr, acc and dptr have no effect on these classes.
- R5: Class 4 (indexed jump) is always taken. Its target is dptr plus acc zero-extended, modulo 2^16.
- R6: Class 5 branches when acc == 0 and class 6 branches when acc != 0. Both use the relative target.
- R7: Class 7 branches when cy_in = 1, class 8 when cy_in = 0, class 9 when bit_val = 1 and class 10 when bit_val = 0. All four use the relative target.
- R8: Class 11 (compare) branches to the relative target exactly when opnd_a != opnd_b.
- R9: For class 11, cy_out = 1 when opnd_a < opnd_b as unsigned values and 0 otherwise. For every other class, cy_out = cy_in.
- R10: dec_val = dec_src - 1 modulo 256, so 00h gives FFh. Class 12 branches to the relative target exactly when dec_val != 0.
- R11: ret_addr equals seq_pc for every class, including both call classes.
- R12: Class 15 is reserved and behaves as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| seq_pc | input | 16 | Address of the next sequential instruction |
| br_class | input | 4 | Branch class code |
| rel_off | input | 8 | Signed relative offset |
| page_addr | input | 11 | In-page target field |
| abs_addr | input | 16 | Full target address |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cy_in | input | 1 | Current carry flag |
| bit_val | input | 1 | Value of the tested bit |
| opnd_a | input | 8 | First compare operand |
| opnd_b | input | 8 | Second compare operand |
| dec_src | input | 8 | Loop count before the decrement |
| next_pc | output | 16 | Next fetch address |
| taken | output | 1 | Flow left the sequential path |
| cy_out | output | 1 | Carry after this instruction |
| dec_val | output | 8 | Decremented loop count |
| ret_addr | output | 16 | Return address for calls |

## Verification
The hardest cases to reach are those where target arithmetic crosses a boundary. Examples are a page call whose sequential address has already moved into the next 2 KB page, a relative or indexed sum that wraps past FFFFh, and a loop count of 00h that wraps and still branches. The vector table sets seq_pc, dptr and dec_src directly to these edge values, so each case needs only one vector. Further vectors hold the class fixed and change an operand that should be ignored, to show that the operand does not reach next_pc.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [3:0] {
    BR_SEQ   = 4'd0,
    BR_SJMP  = 4'd1,
    BR_PJMP  = 4'd2,
    BR_LJMP  = 4'd3,
    BR_XJMP  = 4'd4,
    BR_JZ    = 4'd5,
    BR_JNZ   = 4'd6,
    BR_JC    = 4'd7,
    BR_JNC   = 4'd8,
    BR_JB    = 4'd9,
    BR_JNB   = 4'd10,
    BR_CMP   = 4'd11,
    BR_DJNZ  = 4'd12,
    BR_PCALL = 4'd13,
    BR_LCALL = 4'd14,
    BR_RSVD  = 4'd15
  } br_class_e;

  typedef enum logic [2:0] {
    TG_SEQ  = 3'd0,
    TG_REL  = 3'd1,
    TG_PAGE = 3'd2,
    TG_ABS  = 3'd3,
    TG_IDX  = 3'd4
  } tgt_sel_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import nextpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  br_class_e         cls,
  input  logic [DATA_W-1:0] acc,
  input  logic              cy_in,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] dec_src,
  output tgt_sel_e          sel,
  output logic              taken,
  output logic              cy_out,
  output logic [DATA_W-1:0] dec_val
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic cond_hit;

  // R10: modulo decrement
  assign dec_val = dec_src - ONE;

  always_comb begin
    cond_hit = 1'b0;
    sel      = TG_SEQ;
    case (cls)
      BR_SJMP:  begin cond_hit = 1'b1;                sel = TG_REL;  end
      BR_PJMP:  begin cond_hit = 1'b1;                sel = TG_PAGE; end
      BR_PCALL: begin cond_hit = 1'b1;                sel = TG_PAGE; end
      BR_LJMP:  begin cond_hit = 1'b1;                sel = TG_ABS;  end
      BR_LCALL: begin cond_hit = 1'b1;                sel = TG_ABS;  end
      BR_XJMP:  begin cond_hit = 1'b1;                sel = TG_IDX;  end
      BR_JZ:    begin cond_hit = (acc == '0);         sel = TG_REL;  end
      BR_JNZ:   begin cond_hit = (acc != '0);         sel = TG_REL;  end
      BR_JC:    begin cond_hit = cy_in;               sel = TG_REL;  end
      BR_JNC:   begin cond_hit = !cy_in;              sel = TG_REL;  end
      BR_JB:    begin cond_hit = bit_val;             sel = TG_REL;  end
      BR_JNB:   begin cond_hit = !bit_val;            sel = TG_REL;  end
      BR_CMP:   begin cond_hit = (opnd_a != opnd_b);  sel = TG_REL;  end
      BR_DJNZ:  begin cond_hit = (dec_val != '0);     sel = TG_REL;  end
      default:  begin cond_hit = 1'b0;                sel = TG_SEQ;  end
    endcase
    if (!cond_hit) sel = TG_SEQ;
  end

  assign taken = cond_hit;

  // R9: unsigned compare carry only on compare class
  assign cy_out = (cls == BR_CMP) ? (opnd_a < opnd_b) : cy_in;

endmodule

// File: rtl/npc_target.sv
module npc_target
  import nextpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11
) (
  input  tgt_sel_e          sel,
  input  logic [PC_W-1:0]   seq_pc,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PC_W-1:0]   abs_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  output logic [PC_W-1:0]   next_pc
);

  localparam int EXT_W = PC_W - DATA_W;

  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] idx_tgt;

  // R2: sign-extended offset on sequential address
  assign rel_tgt  = seq_pc + {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
  // R3: low field substituted inside current page
  assign page_tgt = {seq_pc[PC_W-1:PAGE_W], page_addr};
  // R5: accumulator zero-extended onto data pointer
  assign idx_tgt  = dptr + {{EXT_W{1'b0}}, acc};

  always_comb begin
    case (sel)
      TG_REL:  next_pc = rel_tgt;
      TG_PAGE: next_pc = page_tgt;
      TG_ABS:  next_pc = abs_addr;
      TG_IDX:  next_pc = idx_tgt;
      default: next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  parameter int CLS_W  = 4
) (
  input  logic [PC_W-1:0]   seq_pc,
  input  logic [CLS_W-1:0]  br_class,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PC_W-1:0]   abs_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              cy_in,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] dec_src,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              cy_out,
  output logic [DATA_W-1:0] dec_val,
  output logic [PC_W-1:0]   ret_addr
);

  br_class_e cls;
  tgt_sel_e  sel;

  // R12: reserved code decodes to no branch in the condition unit
  assign cls = br_class_e'(br_class[3:0]);

  npc_cond #(.DATA_W(DATA_W)) u_cond (
    .cls     (cls),
    .acc     (acc),
    .cy_in   (cy_in),
    .bit_val (bit_val),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .dec_src (dec_src),
    .sel     (sel),
    .taken   (taken),
    .cy_out  (cy_out),
    .dec_val (dec_val)
  );

  npc_target #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_tgt (
    .sel       (sel),
    .seq_pc    (seq_pc),
    .rel_off   (rel_off),
    .page_addr (page_addr),
    .abs_addr  (abs_addr),
    .acc       (acc),
    .dptr      (dptr),
    .next_pc   (next_pc)
  );

  // R11: return address is the following instruction
  assign ret_addr = seq_pc;

  always_comb begin
    // R1
    seq_hold_chk: assert (taken || (next_pc == seq_pc))
      else $error("untaken flow left the sequential address");
    // R3
    page_hi_chk: assert (!((cls == BR_PJMP) || (cls == BR_PCALL))
                         || (next_pc[PC_W-1:PAGE_W] == seq_pc[PC_W-1:PAGE_W]))
      else $error("page target left its page");
    // R6
    zero_test_chk: assert (!((cls == BR_JZ) && taken) || (acc == '0))
      else $error("zero branch taken on nonzero accumulator");
    // R8
    cmp_ne_chk: assert (!((cls == BR_CMP) && taken) || (opnd_a != opnd_b))
      else $error("compare branch taken on equal operands");
    // R9
    cmp_cy_chk: assert (!((cls == BR_CMP) && cy_out) || taken)
      else $error("compare carry set without branch");
    // R10
    loop_cnt_chk: assert ((cls != BR_DJNZ) || (taken == (dec_val != '0)))
      else $error("loop branch disagrees with count");
    // R12
    rsvd_chk: assert ((cls != BR_RSVD) || !taken)
      else $error("reserved class branched");
  end

endmodule

// File: tb/sim_nextpc_unit.sv
`timescale 1ns/1ps
module sim_nextpc_unit;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  cls;
    logic [15:0] seq;
    logic [7:0]  rel;
    logic [10:0] pg;
    logic [15:0] abs_a;
    logic [7:0]  acc;
    logic [15:0] dp;
    logic        cy;
    logic        bt;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ds;
    logic [15:0] e_pc;
    logic        e_tk;
    logic        e_cy;
    logic [7:0]  e_dec;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [0:NV-1] = '{
    // R1 sequential
    '{8'd1, 4'd0, 16'h1234, 8'h10, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1234, 1'b0, 1'b1, 8'h04},
    // R2 short jump backward (15h + FEh -> 13h)
    '{8'd2, 4'd1, 16'h0015, 8'hFE, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0013, 1'b1, 1'b0, 8'h00},
    // R2 max forward
    '{8'd2, 4'd1, 16'h0100, 8'h7F, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h017F, 1'b1, 1'b0, 8'h00},
    // R2 max backward
    '{8'd2, 4'd1, 16'h0100, 8'h80, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0080, 1'b1, 1'b0, 8'h00},
    // R2 wrap past top
    '{8'd2, 4'd1, 16'hFFF0, 8'h20, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0010, 1'b1, 1'b0, 8'h00},
    // R3 page jump, sequential address already in next page
    '{8'd3, 4'd2, 16'h3800, 8'h00, 11'h123, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h3923, 1'b1, 1'b0, 8'h00},
    // R3 page call
    '{8'd3, 4'd13, 16'h0FFE, 8'h00, 11'h0AB, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h08AB, 1'b1, 1'b0, 8'h00},
    // R4 long jump
    '{8'd4, 4'd3, 16'h0010, 8'h55, 11'h3FF, 16'hBEEF, 8'h12, 16'h3333, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'hBEEF, 1'b1, 1'b0, 8'h00},
    // R4 long call
    '{8'd4, 4'd14, 16'h2002, 8'hAA, 11'h111, 16'h4000, 8'hFF, 16'hFFFF, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 16'h4000, 1'b1, 1'b1, 8'h00},
    // R5 indexed carry into upper byte
    '{8'd5, 4'd4, 16'h0000, 8'h00, 11'h000, 16'h0000, 8'hF0, 16'h1FFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h20EF, 1'b1, 1'b0, 8'h00},
    // R5 indexed wrap
    '{8'd5, 4'd4, 16'h0000, 8'h00, 11'h000, 16'h0000, 8'h02, 16'hFFFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0001, 1'b1, 1'b0, 8'h00},
    // R6 zero branch taken
    '{8'd6, 4'd5, 16'h0200, 8'h10, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0210, 1'b1, 1'b0, 8'h00},
    // R6 zero branch not taken
    '{8'd6, 4'd5, 16'h0200, 8'h10, 11'h000, 16'h0000, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0200, 1'b0, 1'b0, 8'h00},
    // R6 nonzero branch taken backward
    '{8'd6, 4'd6, 16'h0200, 8'hF0, 11'h000, 16'h0000, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h01F0, 1'b1, 1'b0, 8'h00},
    // R7 carry set branch
    '{8'd7, 4'd7, 16'h0300, 8'h04, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0304, 1'b1, 1'b1, 8'h00},
    // R7 carry clear branch not taken
    '{8'd7, 4'd8, 16'h0300, 8'h04, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0300, 1'b0, 1'b1, 8'h00},
    // R7 bit set branch
    '{8'd7, 4'd9, 16'h0400, 8'h08, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h01, 16'h0408, 1'b1, 1'b0, 8'h00},
    // R7 bit clear branch
    '{8'd7, 4'd10, 16'h0400, 8'h08, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0408, 1'b1, 1'b0, 8'h00},
    // R7 bit set branch not taken
    '{8'd7, 4'd9, 16'h0400, 8'h08, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0400, 1'b0, 1'b0, 8'h00},
    // R8 R9 compare a<b
    '{8'd8, 4'd11, 16'h0500, 8'h06, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h10, 8'h20, 8'h01, 16'h0506, 1'b1, 1'b1, 8'h00},
    // R9 compare a>b clears carry
    '{8'd9, 4'd11, 16'h0500, 8'h06, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h20, 8'h10, 8'h01, 16'h0506, 1'b1, 1'b0, 8'h00},
    // R8 R9 compare equal
    '{8'd8, 4'd11, 16'h0500, 8'h06, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h33, 8'h33, 8'h01, 16'h0500, 1'b0, 1'b0, 8'h00},
    // R9 unsigned: 7Fh < 80h
    '{8'd9, 4'd11, 16'h0500, 8'h06, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h7F, 8'h80, 8'h01, 16'h0506, 1'b1, 1'b1, 8'h00},
    // R10 count reaches zero
    '{8'd10, 4'd12, 16'h0600, 8'hFC, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0600, 1'b0, 1'b0, 8'h00},
    // R10 count wraps 00h -> FFh, taken
    '{8'd10, 4'd12, 16'h0600, 8'hFC, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h05FC, 1'b1, 1'b0, 8'hFF},
    // R10 ordinary count
    '{8'd10, 4'd12, 16'h0600, 8'h02, 11'h000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h0A, 16'h0602, 1'b1, 1'b1, 8'h09},
    // R12 reserved class
    '{8'd12, 4'd15, 16'h7777, 8'h10, 11'h7FF, 16'hFFFF, 8'h00, 16'hFFFF, 1'b1, 1'b1, 8'h01, 8'h02, 8'h03, 16'h7777, 1'b0, 1'b1, 8'h02}
  };

  logic        clk;
  logic [15:0] seq_pc, abs_addr, dptr, next_pc, ret_addr;
  logic [3:0]  br_class;
  logic [7:0]  rel_off, acc, opnd_a, opnd_b, dec_src, dec_val;
  logic [10:0] page_addr;
  logic        cy_in, bit_val, taken, cy_out;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  nextpc_unit u0 (
    .seq_pc(seq_pc), .br_class(br_class), .rel_off(rel_off), .page_addr(page_addr),
    .abs_addr(abs_addr), .acc(acc), .dptr(dptr), .cy_in(cy_in), .bit_val(bit_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dec_src(dec_src), .next_pc(next_pc),
    .taken(taken), .cy_out(cy_out), .dec_val(dec_val), .ret_addr(ret_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    br_class = v.cls; seq_pc = v.seq; rel_off = v.rel; page_addr = v.pg;
    abs_addr = v.abs_a; acc = v.acc; dptr = v.dp; cy_in = v.cy; bit_val = v.bt;
    opnd_a = v.a; opnd_b = v.b; dec_src = v.ds;
    @(negedge clk);
  endtask

  initial begin
    br_class = '0; seq_pc = '0; rel_off = '0; page_addr = '0; abs_addr = '0;
    acc = '0; dptr = '0; cy_in = 1'b0; bit_val = 1'b0; opnd_a = '0; opnd_b = '0; dec_src = '0;
    @(negedge clk);
    // R1 quiet state with all inputs zero
    chk("R1 idle next_pc", next_pc, 16'h0000);
    chk("R1 idle taken", {15'd0, taken}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      apply(VECS[i]);
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      chk({tg, " next_pc"}, next_pc, VECS[i].e_pc);
      chk({tg, " taken"}, {15'd0, taken}, {15'd0, VECS[i].e_tk});
      chk({tg, " cy_out"}, {15'd0, cy_out}, {15'd0, VECS[i].e_cy});
      chk({tg, " dec_val"}, {8'd0, dec_val}, {8'd0, VECS[i].e_dec});
      // R11 return address follows sequential address
      chk({tg, " R11 ret_addr"}, ret_addr, VECS[i].seq);
    end

    // R4 ignored operands: long jump target unchanged by rel/page/acc/dptr
    begin
      vec_t v;
      v = VECS[7];
      v.rel = 8'h01; v.pg = 11'h001; v.acc = 8'h80; v.dp = 16'h0101;
      apply(v);
      chk("R4 ignored operands next_pc", next_pc, 16'hBEEF);
    end

    // R3 page call from very top of code space
    begin
      vec_t v;
      v = VECS[6];
      v.seq = 16'hFFFF; v.pg = 11'h000;
      apply(v);
      chk("R3 top page call next_pc", next_pc, 16'hF800);
      chk("R11 top page call ret_addr", ret_addr, 16'hFFFF);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule